// File: doc/BRIEF.md
# Host Signal Packet Framer

The framer sits between a 32-bit host link and the compute-resource tracker of an accelerator. Every incoming word is classified. A word whose top byte is the marker 8'hFF and whose next byte has exactly one bit set opens a signal. Every other word is passed straight through to a data port, so that memory contents are never taken for control traffic. A kernel request signal carries one bitmap word for each group of 32 compute regions. The framer collects these words and hands the whole bitmap to the tracker in one cycle. Other signals are reported as a single event carrying their opcode.

In the outgoing direction, the framer turns a 3-bit command code into a two-word signal: a start word carrying the one-hot opcode, then an end word. Both directions use valid/ready handshakes.

Top module: `hsig_framer`

## Requirements
- R1: After reset, req_valid, evt_valid, frame_err and tx_valid are 0 and cmd_ready is 1.
- R2: When no signal is open, a word that does not start a signal appears on pass_data with pass_valid in the same cycle. in_ready then follows pass_ready.
- R3: A word opens a signal only when bits [31:24] are 8'hFF and bits [23:16] have exactly one bit set. A word with 8'hFF on top and an opcode byte of 8'h00, or with two or more bits set, is passed through as data.
- R4: Opcode 8'h01 opens a request. It is followed by CR_WORDS = ceil(NUM_CR/32) bitmap words and an end word whose bits [31:24] are 8'hFE. In the cycle after the end word is accepted, req_valid is 1 for exactly one cycle. The k-th bitmap word then sits in req_map[32k+31:32k].
- R5: Inside a request, each bitmap word is stored whatever its value, including values whose top byte is 8'hFF.
- R6: If the word in the end position does not have 8'hFE as its top byte, the framer drops that word. frame_err is 1 for one cycle in the following cycle, no req_valid or evt_valid is given, and req_map keeps its previous value.
- R7: Any other one-hot opcode must be followed directly by an end word. After the end word is accepted, evt_valid is 1 for one cycle with evt_op equal to the opcode. A missing end word gives frame_err as in R6.
- R8: A command accepted with code c produces tx_data = {8'hFF, 8'h1<<c, 16'h0}, followed by {8'hFE, 24'h0}. Each word is held stable while tx_ready is 0. cmd_ready is 0 until the end word has been accepted.
- R9: While a signal is open, in_ready is 1 whatever the value of pass_ready, and pass_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host word valid |
| in_data | input | 32 | Host word |
| in_ready | output | 1 | Host word accepted |
| pass_valid | output | 1 | Pass-through word valid |
| pass_data | output | 32 | Pass-through word |
| pass_ready | input | 1 | Pass-through sink ready |
| req_valid | output | 1 | One-cycle pulse: request bitmap complete |
| req_map | output | 32*CR_WORDS | Requested compute-region bitmap |
| evt_valid | output | 1 | One-cycle pulse: non-request signal complete |
| evt_op | output | 8 | Opcode of that signal |
| frame_err | output | 1 | One-cycle pulse: end word missing |
| cmd_valid | input | 1 | Outgoing signal command valid |
| cmd_code | input | 3 | Bit index of the outgoing opcode |
| cmd_ready | output | 1 | Command accepted |
| tx_valid | output | 1 | Outgoing word valid |
| tx_data | output | 32 | Outgoing word |
| tx_ready | input | 1 | Outgoing sink ready |

## Verification
The classifier is exercised with several kinds of word:
- plain data;
- words that carry the marker but an opcode byte of zero or with several bits set;
- words that carry a lone end marker.

Together these separate the marker test from the one-hot opcode test.

Requests are sent with bitmap words that look like start words, to show that the payload is counted and not decoded. A request with a corrupted end word shows that the partial bitmap never reaches the tracker. Outgoing commands are sent at both ends of the code range and under back-pressure, which tests the opcode placement and the holding of each word.

// File: rtl/hsig_pkg.sv
package hsig_pkg;
  localparam logic [7:0] MARK_START = 8'hFF;
  localparam logic [7:0] MARK_END   = 8'hFE;
  localparam logic [7:0] OP_REQUEST = 8'h01;

  typedef enum logic [1:0] {RX_IDLE, RX_MAP, RX_END} rx_state_e;
  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_STOP} tx_state_e;

  function automatic logic opcode_ok(input logic [7:0] b);
    return $onehot(b);
  endfunction
endpackage

// File: rtl/hsig_rst_sync.sv
module hsig_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/hsig_rx.sv
module hsig_rx
  import hsig_pkg::*;
#(
  parameter int CR_WORDS = 2,
  localparam int IDXW = (CR_WORDS > 1) ? $clog2(CR_WORDS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [31:0]           in_data,
  output logic                  in_ready,
  output logic                  pass_valid,
  output logic [31:0]           pass_data,
  input  logic                  pass_ready,
  output logic                  req_valid,
  output logic [32*CR_WORDS-1:0] req_map,
  output logic                  evt_valid,
  output logic [7:0]            evt_op,
  output logic                  frame_err
);
  rx_state_e             state_q, state_d;
  logic [IDXW-1:0]       idx_q, idx_d;
  logic [7:0]            op_q, op_d;
  logic [32*CR_WORDS-1:0] buf_q, map_q;
  logic                  req_q, req_d, evt_q, evt_d, err_q, err_d;
  logic                  is_start, accept, buf_we, map_we;

  assign is_start   = (in_data[31:24] == MARK_START) && opcode_ok(in_data[23:16]);
  assign accept     = in_valid && in_ready;
  assign in_ready   = (state_q == RX_IDLE && !is_start) ? pass_ready : 1'b1;
  assign pass_valid = in_valid && (state_q == RX_IDLE) && !is_start;
  assign pass_data  = in_data;
  assign buf_we     = accept && (state_q == RX_MAP);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    op_d    = op_q;
    req_d   = 1'b0;
    evt_d   = 1'b0;
    err_d   = 1'b0;
    map_we  = 1'b0;
    unique case (state_q)
      RX_IDLE: if (accept && is_start) begin
        op_d    = in_data[23:16];
        idx_d   = '0;
        state_d = (in_data[23:16] == OP_REQUEST) ? RX_MAP : RX_END;
      end
      RX_MAP: if (accept) begin
        if (idx_q == IDXW'(CR_WORDS - 1)) state_d = RX_END;
        else idx_d = idx_q + 1'b1;
      end
      RX_END: if (accept) begin
        state_d = RX_IDLE;
        if (in_data[31:24] == MARK_END) begin
          if (op_q == OP_REQUEST) begin
            req_d  = 1'b1;
            map_we = 1'b1;
          end else begin
            evt_d = 1'b1;
          end
        end else begin
          err_d = 1'b1;
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      idx_q   <= '0;
      op_q    <= '0;
      req_q   <= 1'b0;
      evt_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      op_q    <= op_d;
      req_q   <= req_d;
      evt_q   <= evt_d;
      err_q   <= err_d;
    end
  end

  for (genvar w = 0; w < CR_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           buf_q[32*w +: 32] <= '0;
      else if (buf_we && idx_q == IDXW'(w)) buf_q[32*w +: 32] <= in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      map_q <= '0;
    else if (map_we) map_q <= buf_q;
  end

  assign req_valid = req_q;
  assign req_map   = map_q;
  assign evt_valid = evt_q;
  assign evt_op    = op_q;
  assign frame_err = err_q;
endmodule

// File: rtl/hsig_tx.sv
module hsig_tx
  import hsig_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_code,
  output logic        cmd_ready,
  output logic        tx_valid,
  output logic [31:0] tx_data,
  input  logic        tx_ready
);
  tx_state_e  state_q, state_d;
  logic [7:0] op_q, op_d;

  assign cmd_ready = (state_q == TX_IDLE);
  assign tx_valid  = (state_q != TX_IDLE);
  assign tx_data   = (state_q == TX_START) ? {MARK_START, op_q, 16'h0000}
                                           : {MARK_END, 24'h000000};

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    unique case (state_q)
      TX_IDLE: if (cmd_valid) begin
        op_d    = 8'h01 << cmd_code;
        state_d = TX_START;
      end
      TX_START: if (tx_ready) state_d = TX_STOP;
      TX_STOP:  if (tx_ready) state_d = TX_IDLE;
      default:  state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      op_q    <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
    end
  end
endmodule

// File: rtl/hsig_framer.sv
module hsig_framer #(
  parameter int NUM_CR = 64,
  localparam int CR_WORDS = (NUM_CR + 31) / 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [31:0]            in_data,
  output logic                   in_ready,
  output logic                   pass_valid,
  output logic [31:0]            pass_data,
  input  logic                   pass_ready,
  output logic                   req_valid,
  output logic [32*CR_WORDS-1:0] req_map,
  output logic                   evt_valid,
  output logic [7:0]             evt_op,
  output logic                   frame_err,
  input  logic                   cmd_valid,
  input  logic [2:0]             cmd_code,
  output logic                   cmd_ready,
  output logic                   tx_valid,
  output logic [31:0]            tx_data,
  input  logic                   tx_ready
);
  logic rst_core_n;

  hsig_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n));

  hsig_rx #(.CR_WORDS(CR_WORDS)) u_rx (
    .clk(clk), .rst_n(rst_core_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .pass_valid(pass_valid), .pass_data(pass_data), .pass_ready(pass_ready),
    .req_valid(req_valid), .req_map(req_map),
    .evt_valid(evt_valid), .evt_op(evt_op), .frame_err(frame_err)
  );

  hsig_tx u_tx (
    .clk(clk), .rst_n(rst_core_n),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_ready(cmd_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );
endmodule

// File: rtl/hsig_framer_chk.sv
module hsig_framer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pass_valid,
  input logic [31:0] pass_data,
  input logic        req_valid,
  input logic        evt_valid,
  input logic [7:0]  evt_op,
  input logic        frame_err,
  input logic        cmd_ready,
  input logic        tx_valid,
  input logic [31:0] tx_data,
  input logic        tx_ready
);
  // R3: nothing that opens a signal leaks onto the data port
  p_pass_not_signal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pass_valid |-> !(pass_data[31:24] == 8'hFF && $onehot(pass_data[23:16])));

  // R4: request completion is a single-cycle pulse
  p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  // R6: an error never coincides with a delivered request or event
  p_err_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !req_valid && !evt_valid);

  // R7: reported events carry a one-hot opcode other than request
  p_evt_opcode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> $onehot(evt_op) && evt_op != 8'h01);

  // R8: an outgoing word is held while stalled
  p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R8: a sent start word is followed by the end word
  p_tx_end_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_data[31:24] == 8'hFF |=> tx_valid && tx_data[31:24] == 8'hFE);

  // R8: no new command accepted while a signal is being sent
  p_cmd_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !cmd_ready);
endmodule

bind hsig_framer hsig_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .pass_valid(pass_valid), .pass_data(pass_data),
  .req_valid(req_valid), .evt_valid(evt_valid), .evt_op(evt_op),
  .frame_err(frame_err), .cmd_ready(cmd_ready),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
);

// File: tb/hsig_framer_bench.sv
module hsig_framer_bench;
  localparam int NUM_CR = 64;
  localparam int CRW = (NUM_CR + 31) / 32;
  localparam int NVEC = 8;
  // each entry: {word}; every entry is expected to pass through unchanged
  localparam logic [31:0] VEC [NVEC] = '{
    32'h1234_5678, 32'hFF00_0000, 32'hFF03_0000, 32'hFE00_0000,
    32'h00FF_0000, 32'hFF81_1111, 32'hFFFF_ABCD, 32'h0101_0101};

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, pass_ready = 1'b1, cmd_valid = 1'b0, tx_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic [2:0]  cmd_code = '0;
  logic in_ready, pass_valid, req_valid, evt_valid, frame_err, cmd_ready, tx_valid;
  logic [31:0] pass_data, tx_data;
  logic [32*CRW-1:0] req_map;
  logic [7:0] evt_op;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hsig_framer #(.NUM_CR(NUM_CR)) u_hsig_framer (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    in_valid = 1'b1; in_data = w;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 req_valid", req_valid, 0);
    check("R1 evt_valid", evt_valid, 0);
    check("R1 frame_err", frame_err, 0);
    check("R1 tx_valid", tx_valid, 0);
    check("R1 cmd_ready", cmd_ready, 1);

    // R2/R3 vector walk: all must pass through
    for (int i = 0; i < NVEC; i++) begin
      in_valid = 1'b1; in_data = VEC[i];
      #1;
      check("R3 pass_valid", pass_valid, 1);
      check("R2 pass_data", pass_data, VEC[i]);
      check("R2 in_ready", in_ready, 1);
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0;
    end

    // R2 back-pressure on data
    pass_ready = 1'b0; in_valid = 1'b1; in_data = 32'h0000_00AA; #1;
    check("R2 in_ready follows pass_ready", in_ready, 0);
    in_valid = 1'b0;

    // R4/R5/R9 request with pass_ready low and a marker-like payload word
    in_valid = 1'b1; in_data = 32'hFF01_0000; #1;
    check("R9 start in_ready", in_ready, 1);
    check("R9 start not passed", pass_valid, 0);
    @(posedge clk); @(negedge clk);
    in_data = 32'hA5A5_A5A5; #1;
    check("R9 map in_ready", in_ready, 1);
    @(posedge clk); @(negedge clk);
    in_data = 32'hFF02_1234; #1;
    check("R5 marker word not passed", pass_valid, 0);
    @(posedge clk); @(negedge clk);
    check("R4 no req before end", req_valid, 0);
    push(32'hFE00_0000);
    check("R4 req_valid", req_valid, 1);
    check("R4/R5 req_map", req_map, 64'hFF02_1234_A5A5_A5A5);
    @(negedge clk);
    check("R4 req one cycle", req_valid, 0);
    pass_ready = 1'b1;

    // R6 missing end on a request
    push(32'hFF01_0000); push(32'h1111_1111); push(32'h2222_2222);
    push(32'h1234_5678);
    check("R6 frame_err", frame_err, 1);
    check("R6 no req", req_valid, 0);
    check("R6 map kept", req_map, 64'hFF02_1234_A5A5_A5A5);
    @(negedge clk);
    check("R6 err one cycle", frame_err, 0);
    in_valid = 1'b1; in_data = 32'h0BAD_0BAD; #1;
    check("R6 back in idle", pass_valid, 1);
    in_valid = 1'b0;

    // R7 non-request signal
    push(32'hFF08_0000); push(32'hFE00_0000);
    check("R7 evt_valid", evt_valid, 1);
    check("R7 evt_op", evt_op, 8'h08);
    push(32'hFF40_0000); push(32'h0000_0000);
    check("R7 missing end err", frame_err, 1);
    check("R7 missing end no evt", evt_valid, 0);

    // R8 outgoing signals
    cmd_valid = 1'b1; cmd_code = 3'd1;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    check("R8 start valid", tx_valid, 1);
    check("R8 start word", tx_data, 32'hFF02_0000);
    check("R8 cmd blocked", cmd_ready, 0);
    @(negedge clk);
    check("R8 start held", tx_data, 32'hFF02_0000);
    tx_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 end word", tx_data, 32'hFE00_0000);
    @(posedge clk); @(negedge clk);
    check("R8 idle after", tx_valid, 0);
    tx_ready = 1'b0;
    cmd_valid = 1'b1; cmd_code = 3'd7;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    check("R8 top code", tx_data, 32'hFF80_0000);
    tx_ready = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 done", cmd_ready, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule